// File: doc/BRIEF.md
# Exception Entry Stack Sequencer

This block carries out the entry sequence of a software-raised processor exception. On a one-cycle trigger it captures the program counter, the 32-bit stack pointer, the 16-bit status word and a board-mode flag. It then writes a small frame through a byte-enabled memory write port that uses a valid/ready handshake. The saved program counter goes in as a word and the status word as a halfword. In board mode a single flag byte is also written into the interrupt controller's NMI control register, which sets the system-error flag there. Once the frame is in memory, the block updates the stack pointer, the program counter and the status word in one cycle and then raises a completion pulse.

Stores are little-endian: byte lane k of the data bus is `mem_wdata_o[8k+7:8k]` and covers address `{addr[31:2],2'b00} + k`. Each store is shifted onto its lanes by the low address bits. A trigger that arrives while a sequence is running starts nothing new and is reported on a recursion-error pulse.

The controller has six states. `ST_IDLE` goes to `ST_PUSH_PC` on an accepted trigger. `ST_PUSH_PC` goes to `ST_PUSH_PSW` on a completed handshake. `ST_PUSH_PSW` goes to `ST_SET_FLAG` on a handshake when board mode was captured, and to `ST_COMMIT` on a handshake otherwise. `ST_SET_FLAG` goes to `ST_COMMIT` on a handshake. `ST_COMMIT` goes to `ST_DONE` unconditionally, and `ST_DONE` goes back to `ST_IDLE` unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: `mem_valid_o`, `busy_o`, `done_o`, `recur_err_o` and all three register write strobes are low.
- R2: The first store writes the captured PC to address SP-4. It has byte enables 4'b1111 and PC byte k on lane k, with SP word-aligned.
- R3: The second store writes the captured status word to address SP-8. It has byte enables 4'b0011 and the low status byte on lane 0.
- R4: With board mode captured high, a third store writes byte 0x04 to address 0x34000103 with byte enables 4'b1000, so the data sits in bits 31:24.
- R5: With board mode captured low, only the two stores of R2 and R3 are made.
- R6: The stores go out in the order PC word, status halfword, flag byte. Each one holds `mem_valid_o` with stable address, data and enables until `mem_ready_i` is high at a clock edge, and it counts as exactly one transfer.
- R7: After the last store, `sp_wr_o`, `pc_wr_o` and `psw_wr_o` are high together for one cycle. At that time `sp_o` = SP-8, `pc_o` = 0x40000008, and `psw_o` equals the captured status word with bit 11 (the interrupt enable) cleared and every other bit kept.
- R8: `done_o` is high for exactly one cycle, the cycle after the register write strobes.
- R9: A trigger seen while a sequence is active is ignored and produces a one-cycle `recur_err_o` pulse in the following cycle. The frame, the register updates and the single done pulse are those of the first trigger.
- R10: PC, SP, status and board-mode inputs are captured when the trigger is accepted. Changing them during the sequence has no effect on the stores or the register updates.
- R11: `busy_o` is high from the cycle after an accepted trigger through the done cycle. With `mem_ready_i` held high that is 5 cycles in board mode and 4 cycles otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Exception entry request, one cycle |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current stack pointer (word-aligned) |
| psw_i | input | 16 | Current status word |
| board_en_i | input | 1 | Board mode: also set the controller's system-error flag |
| mem_valid_o | output | 1 | Store request valid |
| mem_ready_i | input | 1 | Store accepted |
| mem_addr_o | output | 32 | Store byte address |
| mem_wdata_o | output | 32 | Store data, lane-aligned |
| mem_be_o | output | 4 | Store byte enables |
| sp_wr_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 32 | New stack pointer |
| pc_wr_o | output | 1 | Program counter update strobe |
| pc_o | output | 32 | New program counter (vector) |
| psw_wr_o | output | 1 | Status word update strobe |
| psw_o | output | 16 | New status word |
| done_o | output | 1 | Sequence finished, one cycle |
| recur_err_o | output | 1 | Nested trigger rejected, one cycle |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench builds the block with its default parameters: interrupt enable at bit 11, vector 0x40000008, flag byte 0x04 at 0x34000103, and a 32-bit data bus. With these values the flag store lands on the top byte lane and the status halfword on the bottom two. Stall patterns on `mem_ready_i` check the hold-until-accepted rule in every store state. A nested trigger and input changes made during a running sequence show that the captured context is the only one in use.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_SET_FLAG,
        ST_COMMIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } xfer_size_e;

endpackage

// File: rtl/exc_lane_align.sv
module exc_lane_align
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  xfer_size_e        size_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W/8-1:0] be_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [OFS_W-1:0]  ofs;
    logic [LANES-1:0]  base_mask;

    assign ofs = addr_i[OFS_W-1:0];

    always_comb begin
        base_mask = '0;
        unique case (size_i)
            SZ_BYTE: base_mask[0]   = 1'b1;
            SZ_HALF: base_mask[1:0] = 2'b11;
            SZ_WORD: base_mask      = '1;
            default: base_mask      = '0;
        endcase
    end

    assign be_o   = base_mask << ofs;
    assign data_o = value_i << (ofs * 8);

endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs #(
    parameter int ADDR_W      = 32,
    parameter int PSW_W       = 16,
    parameter int IE_BIT      = 11,
    parameter int FRAME_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [PSW_W-1:0]  psw_i,
    input  logic              board_en_i,
    output logic [ADDR_W-1:0] pc_q_o,
    output logic [ADDR_W-1:0] sp_q_o,
    output logic [PSW_W-1:0]  psw_q_o,
    output logic              board_q_o,
    output logic [ADDR_W-1:0] sp_new_o,
    output logic [PSW_W-1:0]  psw_new_o
);
    localparam logic [PSW_W-1:0] IE_MASK = PSW_W'(1) << IE_BIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q_o    <= '0;
            sp_q_o    <= '0;
            psw_q_o   <= '0;
            board_q_o <= 1'b0;
        end else if (accept_i) begin
            pc_q_o    <= pc_i;
            sp_q_o    <= sp_i;
            psw_q_o   <= psw_i;
            board_q_o <= board_en_i;
        end
    end

    assign sp_new_o  = sp_q_o - ADDR_W'(FRAME_BYTES);
    assign psw_new_o = psw_q_o & ~IE_MASK;

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic       board_q_i,
    input  logic       mem_ready_i,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       mem_valid_o,
    output logic       commit_o,
    output logic       done_o,
    output logic       busy_o,
    output logic       recur_err_o
);
    seq_state_e state_q, state_d;
    logic       xfer_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign xfer_ok = mem_valid_o && mem_ready_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (trig_i)  state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (xfer_ok) state_d = ST_PUSH_PSW;
            ST_PUSH_PSW: if (xfer_ok) state_d = board_q_i ? ST_SET_FLAG : ST_COMMIT;
            ST_SET_FLAG: if (xfer_ok) state_d = ST_COMMIT;
            ST_COMMIT:                state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o    = 1'b0;
        mem_valid_o = 1'b0;
        commit_o    = 1'b0;
        done_o      = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = trig_i;
            end
            ST_PUSH_PC, ST_PUSH_PSW, ST_SET_FLAG: mem_valid_o = 1'b1;
            ST_COMMIT: commit_o = 1'b1;
            ST_DONE:   done_o   = 1'b1;
            default:   busy_o   = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) recur_err_o <= 1'b0;
        else        recur_err_o <= trig_i && (state_q != ST_IDLE);
    end

    assign state_o = state_q;

    // R9: a nested trigger is answered by an error pulse
    a_r9_nested_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> recur_err_o);

    // R8: completion follows the commit cycle and lasts one cycle
    a_r8_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (done_o && !commit_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1: no store request while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_valid_o && !done_o && !commit_o));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int               ADDR_W      = 32,
    parameter int               DATA_W      = 32,
    parameter int               PSW_W       = 16,
    parameter int               IE_BIT      = 11,
    parameter int               FRAME_BYTES = 8,
    parameter int               PC_SLOT     = 4,
    parameter logic [ADDR_W-1:0] VECTOR     = 32'h4000_0008,
    parameter logic [ADDR_W-1:0] FLAG_ADDR  = 32'h3400_0103,
    parameter logic [7:0]       FLAG_VAL    = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [PSW_W-1:0]  psw_i,
    input  logic              board_en_i,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W/8-1:0] mem_be_o,
    output logic              sp_wr_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              pc_wr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              psw_wr_o,
    output logic [PSW_W-1:0]  psw_o,
    output logic              done_o,
    output logic              recur_err_o,
    output logic              busy_o
);
    localparam int LANES = DATA_W / 8;

    seq_state_e        state;
    logic              accept, commit, board_q;
    logic [ADDR_W-1:0] pc_q, sp_q, sp_new;
    logic [PSW_W-1:0]  psw_q, psw_new;
    logic [ADDR_W-1:0] st_addr;
    xfer_size_e        st_size;
    logic [DATA_W-1:0] st_value;

    exc_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .board_q_i   (board_q),
        .mem_ready_i (mem_ready_i),
        .state_o     (state),
        .accept_o    (accept),
        .mem_valid_o (mem_valid_o),
        .commit_o    (commit),
        .done_o      (done_o),
        .busy_o      (busy_o),
        .recur_err_o (recur_err_o)
    );

    exc_ctx_regs #(
        .ADDR_W      (ADDR_W),
        .PSW_W       (PSW_W),
        .IE_BIT      (IE_BIT),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .pc_i       (pc_i),
        .sp_i       (sp_i),
        .psw_i      (psw_i),
        .board_en_i (board_en_i),
        .pc_q_o     (pc_q),
        .sp_q_o     (sp_q),
        .psw_q_o    (psw_q),
        .board_q_o  (board_q),
        .sp_new_o   (sp_new),
        .psw_new_o  (psw_new)
    );

    always_comb begin
        st_addr  = '0;
        st_size  = SZ_BYTE;
        st_value = '0;
        unique case (state)
            ST_PUSH_PC: begin
                st_addr  = sp_q - ADDR_W'(PC_SLOT);
                st_size  = SZ_WORD;
                st_value = DATA_W'(pc_q);
            end
            ST_PUSH_PSW: begin
                st_addr  = sp_new;
                st_size  = SZ_HALF;
                st_value = DATA_W'(psw_q);
            end
            ST_SET_FLAG: begin
                st_addr  = FLAG_ADDR;
                st_size  = SZ_BYTE;
                st_value = DATA_W'(FLAG_VAL);
            end
            default: ;
        endcase
    end

    exc_lane_align #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_align (
        .addr_i  (st_addr),
        .size_i  (st_size),
        .value_i (st_value),
        .be_o    (mem_be_o),
        .data_o  (mem_wdata_o)
    );

    assign mem_addr_o = st_addr;
    assign sp_wr_o    = commit;
    assign pc_wr_o    = commit;
    assign psw_wr_o   = commit;
    assign sp_o       = sp_new;
    assign pc_o       = VECTOR;
    assign psw_o      = psw_new;

    // R6: a pending store keeps its fields until accepted
    a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
        (mem_valid_o && $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_be_o)));

    // R7: the new status word never carries the interrupt enable
    a_r7_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        psw_wr_o |-> !psw_o[IE_BIT]);

    // R7: stack pointer moves by the frame size relative to the stored word
    a_r7_sp_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_PC) |-> (mem_addr_o - sp_new == ADDR_W'(FRAME_BYTES - PC_SLOT)));

    // R6: byte enables are never empty on a valid store
    a_r6_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> (mem_be_o != '0));

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic [31:0] pc_i = '0, sp_i = '0;
    logic [15:0] psw_i = '0;
    logic        board_en_i = 1'b0;
    logic        mem_ready_i = 1'b1;
    logic        mem_valid_o;
    logic [31:0] mem_addr_o, mem_wdata_o, sp_o, pc_o;
    logic [3:0]  mem_be_o;
    logic        sp_wr_o, pc_wr_o, psw_wr_o, done_o, recur_err_o, busy_o;
    logic [15:0] psw_o;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .pc_i(pc_i), .sp_i(sp_i),
        .psw_i(psw_i), .board_en_i(board_en_i), .mem_valid_o(mem_valid_o),
        .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_be_o(mem_be_o), .sp_wr_o(sp_wr_o), .sp_o(sp_o), .pc_wr_o(pc_wr_o),
        .pc_o(pc_o), .psw_wr_o(psw_wr_o), .psw_o(psw_o), .done_o(done_o),
        .recur_err_o(recur_err_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    int cyc = 0;
    int n_wr, n_commit, n_done, n_recur, n_busy, commit_cyc, done_cyc, n_strobe_mis;
    logic [31:0] w_addr [0:7];
    logic [31:0] w_data [0:7];
    logic [3:0]  w_be   [0:7];
    logic [31:0] c_sp, c_pc;
    logic [15:0] c_psw;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_wr = 0; n_commit = 0; n_done = 0; n_recur = 0; n_busy = 0;
        commit_cyc = -1; done_cyc = -1; n_strobe_mis = 0;
    endtask

    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (mem_valid_o && mem_ready_i && n_wr < 8) begin
                w_addr[n_wr] = mem_addr_o;
                w_data[n_wr] = mem_wdata_o;
                w_be[n_wr]   = mem_be_o;
                n_wr++;
            end
            if (sp_wr_o) begin
                n_commit++; commit_cyc = cyc;
                c_sp = sp_o; c_pc = pc_o; c_psw = psw_o;
            end
            if ((sp_wr_o != pc_wr_o) || (sp_wr_o != psw_wr_o)) n_strobe_mis++;
            if (done_o) begin n_done++; done_cyc = cyc; end
            if (recur_err_o) n_recur++;
            if (busy_o) n_busy++;
        end
    end

    // stall: 0 none, 1 ready every third cycle; nest: fire a second trigger; perturb inputs
    task automatic run_entry(input logic [31:0] pc, input logic [31:0] sp, input logic [15:0] psw,
                             input logic board, input int stall, input bit nest, input bit perturb);
        clear_log();
        @(negedge clk);
        pc_i = pc; sp_i = sp; psw_i = psw; board_en_i = board; trig_i = 1'b1;
        mem_ready_i = (stall == 0);
        @(negedge clk);
        trig_i = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (stall != 0) mem_ready_i = (k % 3 == 2);
            if (perturb) begin
                pc_i = ~pc; sp_i = sp + 32'h100; psw_i = ~psw; board_en_i = ~board;
            end
            trig_i = nest && (k == 1);
            @(negedge clk);
            if (n_done > 0 && k > 3) break;
        end
        trig_i = 1'b0;
        mem_ready_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input logic [31:0] pc, input logic [31:0] sp,
                               input logic [15:0] psw, input logic board);
        chk({tag, " R5 store count"}, n_wr, board ? 3 : 2);
        chk({tag, " R2 pc addr"}, w_addr[0], sp - 4);
        chk({tag, " R2 pc data"}, w_data[0], pc);
        chk({tag, " R2 pc be"}, {28'b0, w_be[0]}, 32'hF);
        chk({tag, " R3 psw addr"}, w_addr[1], sp - 8);
        chk({tag, " R3 psw data"}, w_data[1] & 32'h0000_FFFF, {16'b0, psw});
        chk({tag, " R3 psw be"}, {28'b0, w_be[1]}, 32'h3);
        if (board) begin
            chk({tag, " R4 flag addr"}, w_addr[2], 32'h3400_0103);
            chk({tag, " R4 flag data"}, w_data[2] & 32'hFF00_0000, 32'h0400_0000);
            chk({tag, " R4 flag be"}, {28'b0, w_be[2]}, 32'h8);
        end
        chk({tag, " R7 commit count"}, n_commit, 1);
        chk({tag, " R7 strobes together"}, n_strobe_mis, 0);
        chk({tag, " R7 sp"}, c_sp, sp - 8);
        chk({tag, " R7 pc"}, c_pc, 32'h4000_0008);
        chk({tag, " R7 psw"}, {16'b0, c_psw}, {16'b0, psw & 16'hF7FF});
        chk({tag, " R8 done count"}, n_done, 1);
        chk({tag, " R8 done timing"}, done_cyc, commit_cyc + 1);
    endtask

    task automatic t_reset();
        chk("R1 valid", mem_valid_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 recur", recur_err_o, 0);
        chk("R1 strobes", {sp_wr_o, pc_wr_o, psw_wr_o}, 0);
    endtask

    task automatic t_board_on();
        run_entry(32'h1234_5678, 32'h0000_1000, 16'h8A5C | 16'h0800, 1'b1, 0, 0, 0);
        check_frame("board", 32'h1234_5678, 32'h0000_1000, 16'h8A5C | 16'h0800, 1'b1);
        chk("R11 busy cycles board", n_busy, 5);
        chk("R9 no spurious recur", n_recur, 0);
    endtask

    task automatic t_board_off();
        run_entry(32'hCAFE_0010, 32'h2000_0040, 16'hFFFF, 1'b0, 0, 0, 0);
        check_frame("plain", 32'hCAFE_0010, 32'h2000_0040, 16'hFFFF, 1'b0);
        chk("R11 busy cycles plain", n_busy, 4);
    endtask

    task automatic t_ie_clear_kept();
        run_entry(32'h0000_0002, 32'h0000_0010, 16'h0123, 1'b1, 0, 0, 0);
        check_frame("ie0", 32'h0000_0002, 32'h0000_0010, 16'h0123, 1'b1);
    endtask

    task automatic t_stall();
        run_entry(32'hA1B2_C3D4, 32'h4000_8000, 16'h5A0F, 1'b1, 1, 0, 0);
        check_frame("R6 stall", 32'hA1B2_C3D4, 32'h4000_8000, 16'h5A0F, 1'b1);
    endtask

    task automatic t_nested();
        run_entry(32'h0BAD_F00D, 32'h0000_3000, 16'h0800, 1'b1, 0, 1, 0);
        check_frame("R9 nested", 32'h0BAD_F00D, 32'h0000_3000, 16'h0800, 1'b1);
        chk("R9 recur pulse count", n_recur, 1);
    endtask

    task automatic t_perturb();
        run_entry(32'h7654_3210, 32'h0000_5000, 16'h0FF0, 1'b0, 1, 0, 1);
        pc_i = '0; sp_i = '0; psw_i = '0; board_en_i = 1'b0;
        check_frame("R10 capture", 32'h7654_3210, 32'h0000_5000, 16'h0FF0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_board_on();
        t_board_off();
        t_ie_clear_kept();
        t_stall();
        t_nested();
        t_perturb();
        t_board_on();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule